// File: doc/BRIEF.md
# Serial Wire Debug Link Transaction Monitor

This block listens to the clock and data pins of a two-wire serial debug link and never drives either of them. Both pins arrive already synchronised to the local clock. The block takes one bit from the data pin each time the sampled clock rises. It first waits for a line reset, which is a long unbroken run of ones. After that it finds the frame alignment itself, because nothing on the host side marks where a frame starts.

To find a frame, an eight-bit window slides over the bit stream one bit at a time. The window is accepted as a request when its start, stop and park bits and its parity bit are all correct. Any other pattern is skipped, and this includes the mode-switch sequence sent between two line resets. Once a request is accepted, the monitor steps through a fixed phase schedule: turnaround, three acknowledge bits, an optional second turnaround, then a 32-bit data word and its parity bit. At the end it reports the whole transaction as a single-cycle pulse, with every field held on the outputs until the next pulse.

The state machine has seven states:
- ST_HUNT: ignores all bits until the first line reset.
- ST_LRST: the line is in a run of ones.
- ST_SEEK: the sliding search for a request.
- ST_TRN1: the turnaround after the request.
- ST_ACK: the acknowledge bits.
- ST_TRN2: the turnaround that a write takes before its data.
- ST_DATA: the data word and its parity bit.

The transitions are:
- Any state moves to ST_LRST on a line reset.
- ST_HUNT stays where it is until that happens.
- ST_LRST moves to ST_SEEK on the first zero.
- ST_SEEK moves to ST_TRN1 when the window holds a valid request.
- ST_TRN1 always moves to ST_ACK.
- ST_ACK, after its third bit, moves to ST_SEEK on a non-OK code, to ST_DATA for a read, or to ST_TRN2 for a write.
- ST_TRN2 always moves to ST_DATA.
- ST_DATA moves to ST_SEEK after the parity bit.

Top module: `swdmon_top`

## Requirements
- R1: After reset, txn_valid and line_reset are low and all transaction fields (txn_ap, txn_read, txn_addr, txn_ack, txn_data, txn_perr) are zero.
- R2: A run of LRST_LEN (51) consecutive ones sampled on rising edges of swclk_s raises line_reset for exactly one clock. It fires once per run, on the 51st one. A run of 50 ones does not raise it.
- R3: Bits received before the first line reset are never decoded. After any line reset, the request search starts with the first zero bit.
- R4: A request is eight bits. In wire order they are: start=1, port select (1 = access port), read=1/write=0, A2, A3, parity, stop=0, park=1. The parity bit must equal the XOR of port select, read, A2 and A3. The search window slides one bit at a time, so the switch sequence 0111100111100111 between line resets never produces a transaction.
- R5: A window with a parity mismatch or a stop bit of 1 produces no transaction, and the search goes on bit by bit until a later valid request.
- R6: After a request come exactly one turnaround bit and three acknowledge bits. On a read with OK acknowledge, the 33 data-phase bits follow at once. txn_ack holds the first acknowledge bit in bit 0, so the wire sequence 1,0,0 is OK and reads as 3'b001. txn_addr holds A3 in bit 1 and A2 in bit 0.
- R7: On a write with OK acknowledge, exactly one turnaround bit comes between the acknowledge and the data phase. txn_read is 0 and txn_ap reflects the port select.
- R8: The data word is received least significant bit first and is reported on txn_data. txn_perr is 1 exactly when the 33rd bit differs from the XOR of the 32 data bits.
- R9: A non-OK acknowledge reports the transaction after the third acknowledge bit, with txn_data zero and txn_perr zero. No data phase is consumed, and the search resumes with the next bit.
- R10: txn_valid is a one-clock pulse. All transaction fields stay unchanged on every clock where txn_valid is low, line resets included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swclk_s | input | 1 | Synchronised debug link clock |
| swdio_s | input | 1 | Synchronised debug link data |
| txn_valid | output | 1 | One-clock pulse when a transaction is reported |
| txn_ap | output | 1 | 1 = access port, 0 = debug port |
| txn_read | output | 1 | 1 = read, 0 = write |
| txn_addr | output | 2 | Register address, bit 1 = A3, bit 0 = A2 |
| txn_ack | output | 3 | Acknowledge, first wire bit in bit 0 |
| txn_data | output | DATA_W | Data word of the transaction |
| txn_perr | output | 1 | Data parity mismatch |
| line_reset | output | 1 | One-clock pulse on a detected line reset |

## Verification
The checker assumes that each rise of swclk_s is held high for at least one local clock and is preceded by at least one low clock. Under that assumption, pulses on txn_valid and line_reset can never come on two clocks in a row, and every pulse follows a sampled rising edge. The stimulus holds every half period of the link clock for several local clocks, and it changes the data pin only while the link clock is low. The bench also never builds a stream in which a 51-one run could fall inside a data phase, because a data phase is only 33 bits long.

// File: rtl/swdmon_pkg.sv
package swdmon_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LRST,
        ST_SEEK,
        ST_TRN1,
        ST_ACK,
        ST_TRN2,
        ST_DATA
    } mon_state_t;

    typedef struct packed {
        logic       ap;
        logic       rd;
        logic [1:0] addr;
    } mon_req_t;

    localparam int unsigned REQ_BITS = 8;
    localparam int unsigned ACK_BITS = 3;
    localparam logic [ACK_BITS-1:0] ACK_OK = 3'b001;

endpackage

// File: rtl/swdmon_edge.sv
module swdmon_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic swclk_s,
    output logic rise
);
    logic prev_q;

    // Reset high so that a clock already high at reset is not taken as an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= swclk_s;
    end

    assign rise = swclk_s & ~prev_q;
endmodule

// File: rtl/swdmon_run.sv
module swdmon_run #(
    parameter int unsigned RUN_LEN = 51
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_in,
    output logic hit
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] ones_q;

    // Counts consecutive ones and saturates, so a run reports only once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (stb) begin
            if (!bit_in)                        ones_q <= '0;
            else if (ones_q != CW'(RUN_LEN))    ones_q <= ones_q + 1'b1;
        end
    end

    assign hit = stb & bit_in & (ones_q == CW'(RUN_LEN - 1));
endmodule

// File: rtl/swdmon_reqchk.sv
module swdmon_reqchk
    import swdmon_pkg::*;
(
    input  logic [REQ_BITS-1:0] cand,
    output logic                ok,
    output mon_req_t            req
);
    // Wire order: [0] start, [1] port, [2] read, [3] A2, [4] A3,
    // [5] parity, [6] stop, [7] park.
    assign ok = cand[0] & ~cand[6] & cand[7] & (cand[5] == ^cand[4:1]);
    assign req.ap   = cand[1];
    assign req.rd   = cand[2];
    assign req.addr = {cand[4], cand[3]};
endmodule

// File: rtl/swdmon_top.sv
module swdmon_top
    import swdmon_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LRST_LEN = 51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swclk_s,
    input  logic              swdio_s,
    output logic              txn_valid,
    output logic              txn_ap,
    output logic              txn_read,
    output logic [1:0]        txn_addr,
    output logic [2:0]        txn_ack,
    output logic [DATA_W-1:0] txn_data,
    output logic              txn_perr,
    output logic              line_reset
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    mon_state_t           state_q, state_d;
    logic                 stb, hit, req_ok, seek_hit;
    mon_req_t             req_f, cur_req;
    logic [REQ_BITS-1:0]  win_q, cand;
    logic [ACK_BITS-1:0]  ack_q, ack_full;
    logic [DATA_W-1:0]    sh_q;
    logic [CNT_W-1:0]     cnt_q;

    swdmon_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .swclk_s (swclk_s),
        .rise    (stb)
    );

    swdmon_run #(.RUN_LEN(LRST_LEN)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .bit_in (swdio_s),
        .hit    (hit)
    );

    assign cand     = {swdio_s, win_q[REQ_BITS-1:1]};
    assign ack_full = {swdio_s, ack_q[ACK_BITS-1:1]};

    swdmon_reqchk u_req (
        .cand (cand),
        .ok   (req_ok),
        .req  (req_f)
    );

    assign seek_hit = req_ok & (cnt_q >= CNT_W'(REQ_BITS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Next-state logic, advancing once per sampled bit
    always_comb begin
        state_d = state_q;
        if (stb) begin
            if (hit) begin
                state_d = ST_LRST;
            end else begin
                unique case (state_q)
                    ST_HUNT: state_d = ST_HUNT;
                    ST_LRST: if (!swdio_s) state_d = ST_SEEK;
                    ST_SEEK: if (seek_hit) state_d = ST_TRN1;
                    ST_TRN1: state_d = ST_ACK;
                    ST_ACK: begin
                        if (cnt_q == CNT_W'(ACK_BITS - 1)) begin
                            if (ack_full != ACK_OK) state_d = ST_SEEK;
                            else if (cur_req.rd)    state_d = ST_DATA;
                            else                    state_d = ST_TRN2;
                        end
                    end
                    ST_TRN2: state_d = ST_DATA;
                    ST_DATA: if (cnt_q == CNT_W'(DATA_W)) state_d = ST_SEEK;
                    default: state_d = ST_HUNT;
                endcase
            end
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            ack_q      <= '0;
            sh_q       <= '0;
            cnt_q      <= '0;
            cur_req    <= '0;
            txn_valid  <= 1'b0;
            txn_ap     <= 1'b0;
            txn_read   <= 1'b0;
            txn_addr   <= '0;
            txn_ack    <= '0;
            txn_data   <= '0;
            txn_perr   <= 1'b0;
            line_reset <= 1'b0;
        end else begin
            txn_valid  <= 1'b0;
            line_reset <= 1'b0;
            if (stb) begin
                line_reset <= hit;
                win_q      <= cand;
                if (state_d != state_q)            cnt_q <= '0;
                else if (cnt_q != CNT_W'(DATA_W))  cnt_q <= cnt_q + 1'b1;
                if (!hit) begin
                    unique case (state_q)
                        ST_SEEK: if (seek_hit) cur_req <= req_f;
                        ST_ACK: begin
                            ack_q <= ack_full;
                            if (cnt_q == CNT_W'(ACK_BITS - 1) && ack_full != ACK_OK) begin
                                txn_valid <= 1'b1;
                                txn_ap    <= cur_req.ap;
                                txn_read  <= cur_req.rd;
                                txn_addr  <= cur_req.addr;
                                txn_ack   <= ack_full;
                                txn_data  <= '0;
                                txn_perr  <= 1'b0;
                            end
                        end
                        ST_DATA: begin
                            if (cnt_q < CNT_W'(DATA_W)) begin
                                sh_q <= {swdio_s, sh_q[DATA_W-1:1]};
                            end else begin
                                txn_valid <= 1'b1;
                                txn_ap    <= cur_req.ap;
                                txn_read  <= cur_req.rd;
                                txn_addr  <= cur_req.addr;
                                txn_ack   <= ack_q;
                                txn_data  <= sh_q;
                                txn_perr  <= swdio_s ^ (^sh_q);
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/swdmon_chk.sv
module swdmon_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              swclk_s,
    input logic              swdio_s,
    input logic              txn_valid,
    input logic              txn_ap,
    input logic              txn_read,
    input logic [1:0]        txn_addr,
    input logic [2:0]        txn_ack,
    input logic [DATA_W-1:0] txn_data,
    input logic              txn_perr,
    input logic              line_reset
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !txn_valid); // R10

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |-> $stable({txn_ap, txn_read, txn_addr, txn_ack, txn_data, txn_perr})); // R10

    AST_NOK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ack != 3'b001) |-> (txn_data == '0 && !txn_perr)); // R9

    AST_LRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |=> !line_reset); // R2

    AST_LRST_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |-> ($past(swdio_s) && $past(swclk_s))); // R2

    AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> $past(swclk_s)); // R6
endmodule

bind swdmon_top swdmon_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .swclk_s    (swclk_s),
    .swdio_s    (swdio_s),
    .txn_valid  (txn_valid),
    .txn_ap     (txn_ap),
    .txn_read   (txn_read),
    .txn_addr   (txn_addr),
    .txn_ack    (txn_ack),
    .txn_data   (txn_data),
    .txn_perr   (txn_perr),
    .line_reset (line_reset)
);

// File: tb/sim_swdmon_top.sv
`timescale 1ns/1ps
module sim_swdmon_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swclk_s = 1'b0;
    logic        swdio_s = 1'b0;
    logic        txn_valid, txn_ap, txn_read, txn_perr, line_reset;
    logic [1:0]  txn_addr;
    logic [2:0]  txn_ack;
    logic [31:0] txn_data;

    int n_chk = 0;
    int n_fail = 0;
    int m_txn = 0;
    int m_lrst = 0;
    int m_wide = 0;
    logic m_prev = 1'b0;

    always #2 clk = ~clk;

    swdmon_top u0 (
        .clk(clk), .rst_n(rst_n), .swclk_s(swclk_s), .swdio_s(swdio_s),
        .txn_valid(txn_valid), .txn_ap(txn_ap), .txn_read(txn_read),
        .txn_addr(txn_addr), .txn_ack(txn_ack), .txn_data(txn_data),
        .txn_perr(txn_perr), .line_reset(line_reset)
    );

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (txn_valid) m_txn++;
            if (line_reset) m_lrst++;
            if (txn_valid && m_prev) m_wide++;
            m_prev <= txn_valid;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        swdio_s = b;
        swclk_s = 1'b0;
        repeat (3) @(negedge clk);
        swclk_s = 1'b1;
        repeat (4) @(negedge clk);
        swclk_s = 1'b0;
    endtask

    task automatic send_run(input logic b, input int n);
        for (int i = 0; i < n; i++) send_bit(b);
    endtask

    task automatic send_req(input logic ap, input logic rd, input logic [1:0] a,
                            input logic flip_par, input logic stop_b);
        logic [7:0] r;
        r = {1'b1, stop_b, (ap ^ rd ^ a[0] ^ a[1]) ^ flip_par, a[1], a[0], rd, ap, 1'b1};
        for (int i = 0; i < 8; i++) send_bit(r[i]);
    endtask

    // Full transaction: request, turnaround, ack, optional turnaround, data.
    task automatic send_txn(input logic ap, input logic rd, input logic [1:0] a,
                            input logic [2:0] ack, input logic [31:0] d, input logic bad_par);
        send_req(ap, rd, a, 1'b0, 1'b0);
        send_bit(1'b0);
        for (int i = 0; i < 3; i++) send_bit(ack[i]);
        if (ack == 3'b001) begin
            if (!rd) send_bit(1'b0);
            for (int i = 0; i < 32; i++) send_bit(d[i]);
            send_bit((^d) ^ bad_par);
        end
        send_run(1'b0, 3);
    endtask

    task automatic line_rst();
        send_run(1'b1, 56);
        send_run(1'b0, 2);
    endtask

    task automatic t_reset();
        chk("R1 valid", txn_valid, 0);
        chk("R1 line_reset", line_reset, 0);
        chk("R1 fields", {txn_ap, txn_read, txn_addr, txn_ack, txn_perr}, 0);
        chk("R1 data", txn_data, 0);
    endtask

    task automatic t_hunt();
        int c0 = m_txn;
        send_run(1'b0, 4);
        send_txn(1'b0, 1'b1, 2'b00, 3'b001, 32'h0BC11477, 1'b0);
        chk("R3 no decode before line reset", m_txn - c0, 0);
    endtask

    task automatic t_lrst_len();
        int l0 = m_lrst;
        send_run(1'b1, 50);
        send_run(1'b0, 2);
        chk("R2 fifty ones no reset", m_lrst - l0, 0);
        send_run(1'b1, 51);
        send_run(1'b0, 2);
        chk("R2 fifty-one ones one reset", m_lrst - l0, 1);
        send_run(1'b1, 120);
        send_run(1'b0, 2);
        chk("R2 long run single pulse", m_lrst - l0, 2);
    endtask

    task automatic t_switch_id();
        logic [15:0] sw = 16'b1110011110011110; // wire order LSB first: 0111100111100111
        int c0 = m_txn;
        int l0 = m_lrst;
        send_run(1'b1, 56);
        for (int i = 0; i < 16; i++) send_bit(sw[i]);
        line_rst();
        chk("R4 switch pattern skipped", m_txn - c0, 0);
        chk("R2 two resets", m_lrst - l0, 2);
        send_txn(1'b0, 1'b1, 2'b00, 3'b001, 32'h0BC11477, 1'b0);
        chk("R4 one transaction", m_txn - c0, 1);
        chk("R6 dp read", {txn_ap, txn_read, txn_addr}, 4'b0100);
        chk("R6 ack ok", txn_ack, 3'b001);
        chk("R8 data lsb first", txn_data, 32'h0BC11477);
        chk("R8 parity good", txn_perr, 0);
    endtask

    task automatic t_write();
        int c0 = m_txn;
        send_txn(1'b1, 1'b0, 2'b01, 3'b001, 32'h23000012, 1'b0);
        chk("R7 one write", m_txn - c0, 1);
        chk("R7 ap write fields", {txn_ap, txn_read, txn_addr}, 4'b1001);
        chk("R7 write data", txn_data, 32'h23000012);
        chk("R7 parity good", txn_perr, 0);
    endtask

    task automatic t_perr();
        send_txn(1'b0, 1'b1, 2'b11, 3'b001, 32'hA5A50F0F, 1'b1);
        chk("R8 data", txn_data, 32'hA5A50F0F);
        chk("R8 parity error", txn_perr, 1);
        chk("R6 addr", txn_addr, 2'b11);
    endtask

    task automatic t_bad_req();
        int c0 = m_txn;
        send_req(1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
        send_run(1'b0, 10);
        send_req(1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
        send_run(1'b0, 10);
        chk("R5 bad requests ignored", m_txn - c0, 0);
        send_txn(1'b1, 1'b1, 2'b10, 3'b001, 32'hFFFFFFFF, 1'b0);
        chk("R5 search resumes", m_txn - c0, 1);
        chk("R5 fields", {txn_ap, txn_read, txn_addr}, 4'b1110);
        chk("R5 data", txn_data, 32'hFFFFFFFF);
    endtask

    task automatic t_wait_ack();
        int c0 = m_txn;
        send_txn(1'b0, 1'b0, 2'b01, 3'b010, 32'h0, 1'b0);
        chk("R9 reported", m_txn - c0, 1);
        chk("R9 ack", txn_ack, 3'b010);
        chk("R9 data zero", txn_data, 0);
        chk("R9 no perr", txn_perr, 0);
        send_txn(1'b0, 1'b1, 2'b00, 3'b001, 32'h12345678, 1'b0);
        chk("R9 next decoded", m_txn - c0, 2);
        chk("R9 next data", txn_data, 32'h12345678);
    endtask

    task automatic t_hold();
        int c0 = m_txn;
        line_rst();
        chk("R10 no txn on reset", m_txn - c0, 0);
        chk("R10 data held", txn_data, 32'h12345678);
        chk("R10 fields held", {txn_ap, txn_read, txn_addr, txn_ack}, 7'b0100001);
        chk("R10 single cycle pulses", m_wide, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hunt();
        t_lrst_len();
        t_switch_id();
        t_write();
        t_perr();
        t_bad_req();
        t_wait_ack();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule